// File: doc/BRIEF.md
# UART Byte FIFO Controller with DMA Ready Handshake

This block holds the receive and transmit byte queues of a classic serial port. The receive queue is filled by the deserializer and drained by host reads. The transmit queue is filled by host writes and drained by the serializer. Writing a single control byte sets the queue behaviour. Bit 0 turns queueing on; when it is off, each direction holds only one byte. Bits 1 and 2 request one-shot clears of the receive and transmit queues. Bit 3 picks the DMA handshake mode. Bits 7:6 select the receive threshold.

The block raises a receive-threshold interrupt request. It also drives two active-low DMA ready pins, `txrdy_n` and `rxrdy_n`. Each pin comes from a two-state machine: `RDY_GO` drives the pin low and `RDY_WAIT` drives it high. In mode 0, the machine follows the occupancy of its queue directly. In mode 1, it moves from `RDY_GO` to `RDY_WAIT` on one event and back on another, and it holds its state between those two events. The ready machines register their decisions, so a pin moves one clock after the queue level that caused it.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, both levels are 0, `ctl_rdata` is 8'h00, `txrdy_n` is 0, `rxrdy_n` is 1 and `rx_irq` is 0.
- R2: A control write with bit 0 set loads bit 3 (DMA mode) and bits 7:6 (threshold code) and sets enable. `ctl_rdata` is {code[1:0], 2'b00, mode, tx clear pending, rx clear pending, enable}. A control write with bit 0 clear only clears enable: mode, code and the clear bits are not taken.
- R3: A control write with bit 0 and bit 1 set makes `ctl_rdata[1]` read 1 for one clock. The receive level is 0 from the following clock, and `ctl_rdata[1]` reads 0 again. Bit 2 does the same for the transmit queue through `ctl_rdata[2]`.
- R4: The threshold codes 00, 01, 10 and 11 mean 1, 4, 8 and 14 bytes. `rx_irq` is high exactly while the receive level is at or above the threshold. With queueing off, the threshold is 1.
- R5: With queueing on, each queue holds 16 bytes; with it off, each holds 1. A push into a full queue is dropped. For the receive side, a dropped push raises `rx_overrun` for one clock.
- R6: Bytes leave in arrival order. Popped data appears on the clock after the pop. A pop of an empty queue repeats the last byte and leaves the level at 0. A push and a pop in the same clock on a non-empty queue leave the level unchanged.
- R7: In mode 0, `txrdy_n` is 0 while the transmit level is 0 and 1 otherwise.
- R8: In mode 0, `rxrdy_n` is 0 while the receive level is at least 1 and 1 otherwise.
- R9: In mode 1, `txrdy_n` goes to 1 when the transmit queue holds 16 bytes. It goes to 0 when the queue is empty, and it holds its value in between.
- R10: In mode 1, `rxrdy_n` goes to 0 when the receive level reaches the threshold, or when `rx_timeout` pulses while the queue is not empty. It returns to 1 only when the receive queue is empty.
- R11: With queueing off, both ready pins follow the mode 0 rules even when the mode bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| ctl_rdata | output | 8 | Control state readback |
| host_wr | input | 1 | Host push into the transmit queue |
| host_wdata | input | 8 | Byte written by the host |
| host_rd | input | 1 | Host pop from the receive queue |
| host_rdata | output | 8 | Last byte popped from the receive queue |
| rx_push | input | 1 | Deserializer push into the receive queue |
| rx_pdata | input | 8 | Received byte |
| tx_pop | input | 1 | Serializer pop from the transmit queue |
| tx_pdata | output | 8 | Last byte popped from the transmit queue |
| rx_timeout | input | 1 | Receive time-out pulse |
| rx_level | output | 5 | Receive queue level |
| tx_level | output | 5 | Transmit queue level |
| rx_irq | output | 1 | Receive threshold request |
| rx_overrun | output | 1 | One-clock pulse on a dropped receive push |
| txrdy_n | output | 1 | Transmit DMA ready, active low |
| rxrdy_n | output | 1 | Receive DMA ready, active low |

## Verification
The bench writes a control byte with bit 0 clear but with the mode, clear and threshold bits set. A design that latched those bits anyway would show a changed readback or empty a queue. In mode 1, it samples the ready pins at 15 of 16 bytes and again at 8 of 16 bytes. A design without hold behaviour would flip `txrdy_n` early or late there. The same check applies to `rxrdy_n`, which must stay low while bytes are drained below the threshold. It also runs each threshold code at one byte below and exactly at its level, overfills both the single-byte and the 16-byte receive queues, and pops empty queues. Off-by-one thresholds, lost overrun pulses or a corrupted last byte show up in these cases.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

    typedef enum logic [1:0] {
        TRIG_1  = 2'b00,
        TRIG_4  = 2'b01,
        TRIG_8  = 2'b10,
        TRIG_14 = 2'b11
    } trig_e;

    typedef enum logic {
        RDY_WAIT = 1'b0,
        RDY_GO   = 1'b1
    } rdy_state_e;

    function automatic int unsigned trig_count(input trig_e code);
        int unsigned n;
        unique case (code)
            TRIG_1:  n = 1;
            TRIG_4:  n = 4;
            TRIG_8:  n = 8;
            TRIG_14: n = 14;
            default: n = 1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ufc_ctl_reg.sv
module ufc_ctl_reg
    import ufc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic       en,
    output logic       dma,
    output trig_e      trig,
    output logic       rx_clr,
    output logic       tx_clr,
    output logic [7:0] rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en     <= 1'b0;
            dma    <= 1'b0;
            trig   <= TRIG_1;
            rx_clr <= 1'b0;
            tx_clr <= 1'b0;
        end else begin
            rx_clr <= 1'b0;
            tx_clr <= 1'b0;
            if (wr) begin
                en <= wdata[0];
                if (wdata[0]) begin
                    dma    <= wdata[3];
                    trig   <= trig_e'(wdata[7:6]);
                    rx_clr <= wdata[1];
                    tx_clr <= wdata[2];
                end
            end
        end
    end

    assign rdata = {trig, 2'b00, dma, tx_clr, rx_clr, en};

    // R2: a write with bit 0 clear keeps mode and threshold and drops enable
    a_r2_disable_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wdata[0]) |=> ($stable(dma) && $stable(trig) && !en && !rx_clr && !tx_clr));

endmodule

// File: rtl/ufc_byte_fifo.sv
module ufc_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          single,
    input  logic          push,
    input  logic [W-1:0]  pdata,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          ovf
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cap;
    logic          full, empty, do_push, do_pop;

    assign cap     = single ? CW'(1) : CW'(DEPTH);
    assign full    = (count >= cap);
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty && !clr;
    assign do_push = push && (!full || do_pop) && !clr;

    function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= pdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            dout  <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= push && !do_push && !clr;
            if (clr) begin
                wp    <= '0;
                rp    <= '0;
                count <= '0;
            end else begin
                if (do_push) wp <= nxt_ptr(wp);
                if (do_pop) begin
                    dout <= mem[rp];
                    rp   <= nxt_ptr(rp);
                end
                count <= count + CW'(do_push) - CW'(do_pop);
            end
        end
    end

    // R5: level never exceeds the queue depth
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R5: a drop pulse only follows a push into a full queue
    a_r5_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> $past(full && push));

    // R6: popping an empty queue keeps level zero and the last byte
    a_r6_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> (count == '0 && $stable(dout)));

    // R6: simultaneous push and pop on a non-empty queue keeps the level
    a_r6_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !clr) |=> $stable(count));

endmodule

// File: rtl/ufc_ready_fsm.sv
module ufc_ready_fsm
    import ufc_pkg::*;
#(
    parameter bit TX_SIDE = 1'b1,
    parameter int DEPTH   = 16,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst,
    input  logic [CW-1:0] cnt,
    input  logic          trig_hit,
    input  logic          timeout,
    output logic          rdy_n
);

    localparam rdy_state_e RST_ST = TX_SIDE ? RDY_GO : RDY_WAIT;

    rdy_state_e state, nxt;
    logic       is_empty, is_full;

    assign is_empty = (cnt == '0);
    assign is_full  = (cnt == CW'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RST_ST;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!burst) begin
            if (TX_SIDE) nxt = is_empty ? RDY_GO : RDY_WAIT;
            else         nxt = is_empty ? RDY_WAIT : RDY_GO;
        end else begin
            unique case (state)
                RDY_WAIT: begin
                    if (TX_SIDE) begin
                        if (is_empty) nxt = RDY_GO;
                    end else if (trig_hit || (timeout && !is_empty)) begin
                        nxt = RDY_GO;
                    end
                end
                RDY_GO: begin
                    if (TX_SIDE) begin
                        if (is_full) nxt = RDY_WAIT;
                    end else if (is_empty) begin
                        nxt = RDY_WAIT;
                    end
                end
                default: nxt = RST_ST;
            endcase
        end
    end

    always_comb begin
        rdy_n = (state != RDY_GO);
    end

    generate
        if (TX_SIDE) begin : g_tx_chk
            // R9: in mode 1 the transmit pin only rises on a full queue
            a_r9_rise_full: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(rdy_n) && $past(burst)) |-> $past(is_full));
            // R7: the transmit pin never rises over an empty queue
            a_r7_rise_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rdy_n) |-> !$past(is_empty));
        end else begin : g_rx_chk
            // R10: in mode 1 the receive pin falls on threshold or time-out only
            a_r10_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(rdy_n) && $past(burst)) |-> $past(trig_hit || timeout));
            // R10: the receive pin only releases over an empty queue
            a_r10_rise_empty: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rdy_n) |-> $past(is_empty));
        end
    endgenerate

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import ufc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [7:0]    ctl_wdata,
    output logic [7:0]    ctl_rdata,
    input  logic          host_wr,
    input  logic [W-1:0]  host_wdata,
    input  logic          host_rd,
    output logic [W-1:0]  host_rdata,
    input  logic          rx_push,
    input  logic [W-1:0]  rx_pdata,
    input  logic          tx_pop,
    output logic [W-1:0]  tx_pdata,
    input  logic          rx_timeout,
    output logic [CW-1:0] rx_level,
    output logic [CW-1:0] tx_level,
    output logic          rx_irq,
    output logic          rx_overrun,
    output logic          txrdy_n,
    output logic          rxrdy_n
);

    logic          en, dma, rx_clr, tx_clr, burst, tx_drop;
    trig_e         trig;
    logic [CW-1:0] thresh;

    ufc_ctl_reg u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ctl_wr),
        .wdata  (ctl_wdata),
        .en     (en),
        .dma    (dma),
        .trig   (trig),
        .rx_clr (rx_clr),
        .tx_clr (tx_clr),
        .rdata  (ctl_rdata)
    );

    ufc_byte_fifo #(.DEPTH(DEPTH), .W(W)) u_rxq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (rx_clr),
        .single (!en),
        .push   (rx_push),
        .pdata  (rx_pdata),
        .pop    (host_rd),
        .dout   (host_rdata),
        .count  (rx_level),
        .ovf    (rx_overrun)
    );

    ufc_byte_fifo #(.DEPTH(DEPTH), .W(W)) u_txq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tx_clr),
        .single (!en),
        .push   (host_wr),
        .pdata  (host_wdata),
        .pop    (tx_pop),
        .dout   (tx_pdata),
        .count  (tx_level),
        .ovf    (tx_drop)
    );

    assign thresh = en ? CW'(trig_count(trig)) : CW'(1);
    assign rx_irq = (rx_level >= thresh);
    assign burst  = en && dma;

    ufc_ready_fsm #(.TX_SIDE(1'b1), .DEPTH(DEPTH)) u_txrdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .burst    (burst),
        .cnt      (tx_level),
        .trig_hit (1'b0),
        .timeout  (1'b0),
        .rdy_n    (txrdy_n)
    );

    ufc_ready_fsm #(.TX_SIDE(1'b0), .DEPTH(DEPTH)) u_rxrdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .burst    (burst),
        .cnt      (rx_level),
        .trig_hit (rx_irq),
        .timeout  (rx_timeout),
        .rdy_n    (rxrdy_n)
    );

    // R3: a pending clear empties its queue on the next clock
    a_r3_rx_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> (rx_level == '0));
    a_r3_tx_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |=> (tx_level == '0));

endmodule

// File: tb/uart_fifo_ctl_tb.sv
module uart_fifo_ctl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       rx_push = 1'b0;
    logic [7:0] rx_pdata = '0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_pdata;
    logic       rx_timeout = 1'b0;
    logic [4:0] rx_level, tx_level;
    logic       rx_irq, rx_overrun, txrdy_n, rxrdy_n;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    uart_fifo_ctl u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata),
        .rx_push(rx_push), .rx_pdata(rx_pdata),
        .tx_pop(tx_pop), .tx_pdata(tx_pdata),
        .rx_timeout(rx_timeout),
        .rx_level(rx_level), .tx_level(tx_level),
        .rx_irq(rx_irq), .rx_overrun(rx_overrun),
        .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ctl_write(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v; tick(); ctl_wr = 1'b0;
    endtask

    task automatic rx_in(input logic [7:0] b);
        rx_push = 1'b1; rx_pdata = b; tick(); rx_push = 1'b0;
    endtask

    task automatic host_put(input logic [7:0] b);
        host_wr = 1'b1; host_wdata = b; tick(); host_wr = 1'b0;
    endtask

    task automatic host_get();
        host_rd = 1'b1; tick(); host_rd = 1'b0;
    endtask

    task automatic ser_get();
        tx_pop = 1'b1; tick(); tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 ctl_rdata", ctl_rdata, 8'h00);
        check("R1 rx_level", rx_level, 0);
        check("R1 tx_level", tx_level, 0);
        check("R1 txrdy_n", txrdy_n, 0);
        check("R1 rxrdy_n", rxrdy_n, 1);
        check("R1 rx_irq", rx_irq, 0);
    endtask

    task automatic t_ctl();
        ctl_write(8'hF9);
        check("R2 load enabled", ctl_rdata, 8'hC9);
        ctl_write(8'h08);
        check("R2 disable keeps fields", ctl_rdata, 8'hC8);
        ctl_write(8'h36);
        check("R2 bits ignored while disabled", ctl_rdata, 8'hC8);
    endtask

    task automatic t_disabled();
        host_put(8'h11);
        check("R5 single tx level", tx_level, 1);
        host_put(8'h22);
        check("R5 single tx drop", tx_level, 1);
        check("R11 txrdy_n mode0 rule", txrdy_n, 1);
        ser_get();
        check("R6 tx data", tx_pdata, 8'h11);
        check("R5 tx drained", tx_level, 0);
        ser_get();
        check("R6 tx empty pop repeats", tx_pdata, 8'h11);
        tick();
        check("R11 txrdy_n empty", txrdy_n, 0);
        rx_in(8'h33);
        check("R4 disabled threshold 1", rx_irq, 1);
        rx_in(8'h44);
        check("R5 single rx overrun", rx_overrun, 1);
        check("R5 single rx level", rx_level, 1);
        tick();
        check("R5 overrun one clock", rx_overrun, 0);
        check("R11 rxrdy_n mode0 rule", rxrdy_n, 0);
        host_get();
        check("R6 rx data", host_rdata, 8'h33);
        tick();
        check("R8 rxrdy_n released", rxrdy_n, 1);
    endtask

    task automatic t_mode0();
        ctl_write(8'h07);
        check("R3 clear bits visible", ctl_rdata, 8'h07);
        tick();
        check("R3 clear bits self clear", ctl_rdata, 8'h01);
        check("R3 tx cleared", tx_level, 0);
        rx_in(8'hA1); rx_in(8'hB2); rx_in(8'hC3);
        check("R5 rx level 3", rx_level, 3);
        check("R8 rxrdy_n low", rxrdy_n, 0);
        rx_push = 1'b1; rx_pdata = 8'hD4; host_rd = 1'b1; tick();
        rx_push = 1'b0; host_rd = 1'b0;
        check("R6 push pop data", host_rdata, 8'hA1);
        check("R6 push pop level", rx_level, 3);
        host_get(); check("R6 order B2", host_rdata, 8'hB2);
        host_get(); check("R6 order C3", host_rdata, 8'hC3);
        host_get(); check("R6 order D4", host_rdata, 8'hD4);
        host_get();
        check("R6 empty pop repeats", host_rdata, 8'hD4);
        check("R6 empty pop level", rx_level, 0);
        tick();
        check("R8 rxrdy_n high empty", rxrdy_n, 1);
        check("R7 txrdy_n low empty", txrdy_n, 0);
        host_put(8'h55); tick();
        check("R7 txrdy_n high", txrdy_n, 1);
    endtask

    task automatic t_trigger();
        for (int code = 0; code < 4; code++) begin
            int lvl;
            lvl = (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
            ctl_write({code[1:0], 6'b000011});
            tick();
            for (int k = 0; k < lvl - 1; k++) rx_in(8'(k));
            check($sformatf("R4 below code %0d", code), rx_irq, 0);
            rx_in(8'hEE);
            check($sformatf("R4 at code %0d", code), rx_irq, 1);
        end
        ctl_write(8'hC3);
        check("R3 rx clear pending", ctl_rdata, 8'hC3);
        tick();
        check("R3 rx cleared", rx_level, 0);
        check("R3 rx clear done", ctl_rdata, 8'hC1);
    endtask

    task automatic t_fill();
        for (int k = 0; k < 16; k++) rx_in(8'(k));
        check("R5 full 16", rx_level, 16);
        check("R5 no overrun at 16", rx_overrun, 0);
        rx_in(8'h99);
        check("R5 overrun at 17", rx_overrun, 1);
        check("R5 level held 16", rx_level, 16);
        ctl_write(8'hC3); tick();
    endtask

    task automatic t_mode1_tx();
        ctl_write(8'h0D);
        check("R3 tx clear pending", ctl_rdata, 8'h0D);
        tick();
        check("R3 tx clear done", ctl_rdata, 8'h09);
        check("R3 tx cleared", tx_level, 0);
        tick();
        for (int k = 0; k < 15; k++) host_put(8'(k));
        tick();
        check("R9 low below full", txrdy_n, 0);
        host_put(8'h0F); tick();
        check("R9 high at full", txrdy_n, 1);
        for (int k = 0; k < 8; k++) ser_get();
        tick();
        check("R9 hold at 8", txrdy_n, 1);
        for (int k = 0; k < 8; k++) ser_get();
        tick();
        check("R9 low at empty", txrdy_n, 0);
    endtask

    task automatic t_mode1_rx();
        ctl_write(8'h4B);
        check("R2 mode1 readback", ctl_rdata, 8'h4B);
        tick();
        rx_in(8'h01); rx_in(8'h02); rx_in(8'h03); tick();
        check("R10 high below threshold", rxrdy_n, 1);
        rx_in(8'h04); tick();
        check("R10 low at threshold", rxrdy_n, 0);
        host_get(); host_get(); host_get(); tick();
        check("R10 hold while non-empty", rxrdy_n, 0);
        host_get(); tick();
        check("R10 high at empty", rxrdy_n, 1);
        rx_timeout = 1'b1; tick(); rx_timeout = 1'b0; tick();
        check("R10 timeout on empty ignored", rxrdy_n, 1);
        rx_in(8'h05);
        rx_timeout = 1'b1; tick(); rx_timeout = 1'b0;
        check("R10 low on timeout", rxrdy_n, 0);
        host_get(); tick();
        check("R10 release after timeout drain", rxrdy_n, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_ctl();
        t_disabled();
        t_mode0();
        t_trigger();
        t_fill();
        t_mode1_tx();
        t_mode1_rx();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule